// File: doc/BRIEF.md
# Gate Descriptor Fetch Unit

This block turns an 8-bit interrupt or exception vector into the 8-byte gate descriptor that a processor front end would use to dispatch it. It holds a table register with a 32-bit linear base address and a 16-bit byte limit, which is loaded through a simple write strobe. When a lookup is requested, the block finds the descriptor's address by adding eight times the vector to the base. It then checks that all eight bytes of the entry fall within the inclusive byte limit.

An entry that passes the check is read as two 32-bit words over a ready/valid memory port that allows one outstanding read. The low word is fetched first and the high word second. If the high word marks the slot as present, the unit returns the 64-bit descriptor. If the entry runs past the limit, or its present flag is clear, the unit reports a fault together with a cause bit. The requester sees a single-cycle result pulse and may then issue the next vector.

Top module: `vec_table_fetch`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid` and `result_valid` are both 0.
- R2: The low word of the descriptor is read at base + vector×8, computed modulo 2^32. A base that is not a multiple of 8 is used exactly as written.
- R3: An entry is in range only when vector×8 + 7 is at most the limit. A limit of 0 therefore admits no entry at all, and a limit of 7 admits only vector 0.
- R4: For an out-of-range entry, the unit pulses `result_valid` with `result_fault`=1 and `result_oor`=1, and it issues no memory request.
- R5: For an in-range entry, exactly two reads are issued: first at the R2 address, then at that address + 4. A successful result carries `result_desc` = {high word, low word}.
- R6: Bit 15 of the high word is the present flag. When this bit is 0, the result has `result_fault`=1 and `result_oor`=0. When it is 1, the result has `result_fault`=0.
- R7: A lookup is accepted only while idle. `req_ready` stays 0 from acceptance until the cycle after the result, and `req_valid` is ignored during that time.
- R8: `result_valid` is high for exactly one cycle per lookup, and `req_ready` returns to 1 in the following cycle.
- R9: A pending memory request keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen. No new request is issued until the previous read's `mem_rsp_valid` has arrived.
- R10: A cycle with `tbl_wr_en`=1 loads the base and limit, and these values govern the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Load strobe for the table register |
| tbl_wr_base | input | 32 | New table base address |
| tbl_wr_limit | input | 16 | New inclusive byte limit |
| req_valid | input | 1 | Lookup request |
| req_vector | input | 8 | Vector to look up |
| req_ready | output | 1 | Unit is idle and takes a request |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the 32-bit word to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data |
| result_valid | output | 1 | One-cycle result strobe |
| result_fault | output | 1 | Lookup faulted |
| result_oor | output | 1 | Fault cause: 1 = beyond limit, 0 = not present |
| result_desc | output | 64 | Fetched descriptor, high word in bits 63:32 |

## Verification
The assertions check the following on every cycle: a stalled memory request stays stable, no request overlaps a busy interface, the result pulse lasts one cycle, and the number of reads matches each outcome (none for a range fault, two for a success or an absent slot). They also check that the second read lands four bytes past the first. Only the bench scenarios can show the exact boundary arithmetic: limits of 0, 7, 0x7FE and 0x7FF, address wrap past 2^32, an unaligned base, vector 0 and vector 255, and a descriptor assembled from a memory model with stalls. The same is true of stray requests being ignored while a lookup is busy.

// File: rtl/vec_table_fetch.sv
module vec_table_fetch #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_wr_en,
  input  logic [AW-1:0] tbl_wr_base,
  input  logic [LW-1:0] tbl_wr_limit,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vector,
  output logic          req_ready,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          result_valid,
  output logic          result_fault,
  output logic          result_oor,
  output logic [63:0]   result_desc
);
  localparam int SW = VW + 3;
  localparam int CW = (LW > SW ? LW : SW) + 1;
  localparam int PRESENT_BIT = 15;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD_LO, S_RD_HI, S_DONE, S_FAULT} state_t;

  state_t        state;
  logic [AW-1:0] base_q, addr_q;
  logic [LW-1:0] limit_q;
  logic [VW-1:0] vec_q;
  logic [31:0]   lo_q, hi_q;
  logic          issued_q, oor_q;

  logic [CW-1:0] span_end, limit_ext;
  logic          in_range, rsp_take;

  assign span_end  = CW'({vec_q, 3'b111});
  assign limit_ext = CW'(limit_q);
  assign in_range  = span_end <= limit_ext;
  assign rsp_take  = issued_q && mem_rsp_valid;

  assign req_ready     = state == S_IDLE;
  assign mem_req_valid = (state == S_RD_LO || state == S_RD_HI) && !issued_q;
  assign mem_req_addr  = (state == S_RD_HI) ? addr_q + AW'(4) : addr_q;
  assign result_valid  = state == S_DONE || state == S_FAULT;
  assign result_fault  = state == S_FAULT;
  assign result_oor    = oor_q;
  assign result_desc   = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      base_q   <= '0;
      limit_q  <= '0;
      addr_q   <= '0;
      vec_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      issued_q <= 1'b0;
      oor_q    <= 1'b0;
    end else begin
      if (tbl_wr_en) begin
        base_q  <= tbl_wr_base;
        limit_q <= tbl_wr_limit;
      end
      if (mem_req_valid && mem_req_ready)
        issued_q <= 1'b1;
      case (state)
        S_IDLE: if (req_valid) begin
          vec_q <= req_vector;
          oor_q <= 1'b0;
          state <= S_CHECK;
        end
        S_CHECK: begin
          addr_q <= base_q + AW'({vec_q, 3'b000});
          if (in_range) state <= S_RD_LO;
          else begin
            oor_q <= 1'b1;
            state <= S_FAULT;
          end
        end
        S_RD_LO: if (rsp_take) begin
          lo_q     <= mem_rsp_data;
          issued_q <= 1'b0;
          state    <= S_RD_HI;
        end
        S_RD_HI: if (rsp_take) begin
          hi_q     <= mem_rsp_data;
          issued_q <= 1'b0;
          state    <= mem_rsp_data[PRESENT_BIT] ? S_DONE : S_FAULT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_table_fetch_chk.sv
module vec_table_fetch_chk #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tbl_wr_en,
  input logic [AW-1:0] tbl_wr_base,
  input logic [LW-1:0] tbl_wr_limit,
  input logic          req_valid,
  input logic [VW-1:0] req_vector,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic [31:0]   mem_rsp_data,
  input logic          result_valid,
  input logic          result_fault,
  input logic          result_oor,
  input logic [63:0]   result_desc
);
  logic [1:0]    hs_cnt;
  logic [AW-1:0] first_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_cnt     <= '0;
      first_addr <= '0;
    end else if (req_valid && req_ready) begin
      hs_cnt <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      if (hs_cnt == 2'd0) first_addr <= mem_req_addr;
      if (hs_cnt != 2'd3) hs_cnt <= hs_cnt + 2'd1;
    end
  end

  a_r4_no_read_on_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && result_oor |-> hs_cnt == 2'd0 && result_fault);

  a_r5_two_reads_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && !result_fault |-> hs_cnt == 2'd2);

  a_r5_high_word_offset: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && hs_cnt == 2'd1 |-> mem_req_addr == first_addr + AW'(4));

  a_r6_absent_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && result_fault && !result_oor |-> hs_cnt == 2'd2);

  a_r7_busy_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid && req_ready);

  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind vec_table_fetch vec_table_fetch_chk #(.AW(AW), .LW(LW), .VW(VW)) u_chk (.*);

// File: tb/vec_table_fetch_tb.sv
module vec_table_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [31:0] tbl_wr_base = '0;
  logic [15:0] tbl_wr_limit = '0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        result_valid, result_fault, result_oor;
  logic [63:0] result_desc;

  int checks = 0;
  int fails = 0;

  logic        stall_mode = 1'b0;
  logic        clr_hs = 1'b0;
  int          hs = 0;
  logic [31:0] a0 = '0, a1 = '0;

  always #10 clk = ~clk;

  vec_table_fetch u_dut (.*);

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n || clr_hs) begin
      mem_rsp_valid <= 1'b0;
      hs            <= 0;
      mem_req_ready <= 1'b1;
    end else begin
      mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= word_at(mem_req_addr);
        if (hs == 0) a0 <= mem_req_addr; else a1 <= mem_req_addr;
        hs <= hs + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] b, input logic [15:0] l, input logic [7:0] v,
                        input logic stall, input bit spurious);
    bit got = 0;
    bit busy_bad = 0;
    logic f, o;
    logic [63:0] d;
    int cnt;
    logic [31:0] addr, lo, hi;
    bit exp_oor, exp_abs;
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_base = b; tbl_wr_limit = l;
    stall_mode = stall; clr_hs = 1'b1;
    @(negedge clk);
    tbl_wr_en = 1'b0; clr_hs = 1'b0;
    req_valid = 1'b1; req_vector = v;
    @(negedge clk);
    req_valid = spurious; req_vector = 8'hEE;
    for (int i = 0; i < 200 && !got; i++) begin
      if (result_valid) got = 1;
      else begin
        if (req_ready) busy_bad = 1;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    f = result_fault; o = result_oor; d = result_desc; cnt = hs;
    chk(got, "R8 result arrives", 64'(got), 64'd1);
    if (spurious) chk(!busy_bad, "R7 req_ready low while busy", 64'(busy_bad), 64'd0);
    addr    = b + {21'd0, v, 3'b000};
    lo      = word_at(addr);
    hi      = word_at(addr + 32'd4);
    exp_oor = (int'(v) * 8 + 7) > int'(l);
    exp_abs = !exp_oor && !hi[15];
    chk(o == exp_oor, "R3 range decision", 64'(o), 64'(exp_oor));
    chk(f == (exp_oor || exp_abs), "R6 fault flag", 64'(f), 64'(exp_oor || exp_abs));
    if (exp_oor) chk(cnt == 0, "R4 no read on range fault", 64'(cnt), 64'd0);
    else begin
      chk(cnt == 2, "R5 two reads", 64'(cnt), 64'd2);
      chk(a0 == addr, "R2 low word address", 64'(a0), 64'(addr));
      chk(a1 == addr + 32'd4, "R5 high word address", 64'(a1), 64'(addr + 32'd4));
      if (!exp_abs) chk(d == {hi, lo}, "R5 descriptor", d, {hi, lo});
    end
    @(negedge clk);
    chk(!result_valid && req_ready, "R8 single pulse then ready",
        64'({result_valid, req_ready}), 64'b01);
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] limit;
    logic [7:0]  vec;
    logic        stall;
  } stim_t;

  localparam stim_t STIM [9] = '{
    '{32'h0000_1000, 16'h07FF, 8'h00, 1'b0},
    '{32'h0000_1000, 16'h07FF, 8'hFF, 1'b1},
    '{32'h0000_1000, 16'h07FE, 8'hFF, 1'b0},
    '{32'h0000_1000, 16'h0000, 8'h00, 1'b0},
    '{32'h0000_1000, 16'h0007, 8'h00, 1'b0},
    '{32'h0000_1000, 16'h0007, 8'h01, 1'b0},
    '{32'hFFFF_FFFC, 16'hFFFF, 8'h00, 1'b1},
    '{32'h0000_8000, 16'hFFFF, 8'h02, 1'b0},
    '{32'h0000_1003, 16'hFFFF, 8'h03, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !result_valid, "R1 reset state",
        64'({req_ready, mem_req_valid, result_valid}), 64'b100);

    for (int i = 0; i < 9; i++)
      lookup(STIM[i].base, STIM[i].limit, STIM[i].vec, STIM[i].stall, 1'b0);

    // R7: stray requests held high during a stalled lookup are ignored
    lookup(32'h0000_2000, 16'h00FF, 8'h05, 1'b1, 1'b1);
    // R10: reload with a smaller limit turns the same vector into a range fault
    lookup(32'h0000_2000, 16'h0027, 8'h05, 1'b0, 1'b0);
    lookup(32'h0000_2000, 16'h002E, 8'h05, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule